// File: doc/BRIEF.md
# Banked Memory Map Address Decoder

This block sits between a 16-bit CPU address bus with an 8-bit data path and the memories and register ports behind it. For every address it names the target region, the bank inside that region and the local offset within the bank. It also produces the write strobes for memories, for the cartridge bank controller and for the I/O register port, plus a read strobe for the I/O port. Region, bank, offset and strobes are combinational and are valid in the same cycle as the address.

The bank choices come in from outside: the switchable ROM bank and the external RAM bank from the cartridge controller, its RAM enable and its clock-register select, and the raw video-bank and work-RAM-bank register values. The decoder folds the echo window onto work RAM and promotes work-RAM bank 0 to bank 1 in the upper window. It hides external RAM while that RAM is disabled, and it swaps external RAM for a clock register when the select asks for one.

Read data is returned one cycle after the read. A registered return stage picks the memory data, the I/O data or the fill value 0xFF, according to what the read hit.

Top module: `mem_region_decoder`

## Requirements
- R1: Addresses 0x0000-0x3FFF select the fixed ROM region with bank 0. Addresses 0x4000-0x7FFF select the switchable ROM region with bank `rom_bank_i`. Both use offset addr & 0x3FFF.
- R2: A write anywhere in 0x0000-0x7FFF raises `ctrl_we_o` and never `mem_we_o` or `io_we_o`.
- R3: 0x8000-0x9FFF selects video RAM with bank `vram_bank_i[0]` and offset addr & 0x1FFF.
- R4: While `ram_en_i` is low, 0xA000-0xBFFF selects no region (`region_o` is 0). A write there raises no strobe.
- R5: While `ram_en_i` is high, 0xA000-0xBFFF selects the clock-register region if `clk_sel_i[3]` is set, with bank 0 and offset `clk_sel_i[2:0]`. Otherwise it selects external RAM with bank `ram_bank_i` and offset addr & 0x1FFF.
- R6: 0xC000-0xCFFF selects work RAM bank 0. 0xD000-0xDFFF selects work RAM bank `wram_bank_i[2:0]`, where 0 gives bank 1. The offset is addr & 0x0FFF.
- R7: 0xE000-0xFDFF decodes exactly as addr & 0xDFFF does, for region, bank, offset and strobes.
- R8: 0xFE00-0xFE9F selects the sprite table with offset addr & 0xFF. 0xFEA0-0xFEFF selects no region and raises no strobe.
- R9: 0xFF00-0xFF7F selects the I/O region with offset addr & 0xFF. Reads there raise `io_re_o` and writes raise `io_we_o`.
- R10: 0xFF80-0xFFFE selects high RAM with offset addr & 0x7F. 0xFFFF selects the interrupt-enable region with offset 0.
- R11: `region_o` has at most one bit set. The bits are: 0 fixed ROM, 1 switchable ROM, 2 video RAM, 3 external RAM, 4 clock registers, 5 work RAM, 6 sprite table, 7 I/O, 8 high RAM, 9 interrupt enable. Bank and offset are 0 in every field a region does not use, and all of them follow the address in the same cycle.
- R12: In the cycle after a read (`req_i` high, `we_i` low), `rdata_o` shows 0xFF if the read selected no region, `io_rdata_i` if it selected I/O, and `mem_rdata_i` otherwise. The value holds until the next read, and after reset it is 0xFF.
- R13: `mem_we_o` is raised by writes to video RAM, external RAM, clock registers, work RAM, the sprite table, high RAM and interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | Access is a write |
| addr_i | input | 16 | Bus address |
| rom_bank_i | input | 9 | Switchable ROM bank |
| ram_bank_i | input | 4 | External RAM bank |
| ram_en_i | input | 1 | External RAM enabled |
| clk_sel_i | input | 4 | Bit 3 swaps in clock registers; bits 2:0 pick the register |
| vram_bank_i | input | 8 | Video-bank register value |
| wram_bank_i | input | 8 | Work-RAM-bank register value |
| mem_rdata_i | input | 8 | Data returned by the selected memory |
| io_rdata_i | input | 8 | Data returned by the I/O register port |
| region_o | output | 10 | One-hot region select |
| bank_o | output | 9 | Bank number in the region |
| offset_o | output | 14 | Offset in the bank |
| mem_we_o | output | 1 | Memory write strobe |
| ctrl_we_o | output | 1 | Bank-controller command write |
| io_re_o | output | 1 | I/O register read |
| io_we_o | output | 1 | I/O register write |
| rdata_o | output | 8 | Read data returned to the CPU |

## Verification
Region, bank, offset and all four strobes are due in the same cycle as the address. The bench therefore compares them at the falling edge that follows each new stimulus. Read data is due one rising edge later. The bench reference records the kind of each read at the rising edge, and at the next falling edge it compares `rdata_o` against the data inputs present at that moment. The data inputs are changed on every cycle, so a wrong latency shows up as a mismatch.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int NREG = 10;
  localparam int RG_ROM0 = 0;
  localparam int RG_ROMX = 1;
  localparam int RG_VRAM = 2;
  localparam int RG_XRAM = 3;
  localparam int RG_CLK  = 4;
  localparam int RG_WRAM = 5;
  localparam int RG_OAM  = 6;
  localparam int RG_IO   = 7;
  localparam int RG_HRAM = 8;
  localparam int RG_IE   = 9;

  typedef enum logic [1:0] {
    RK_FILL = 2'd0,
    RK_MEM  = 2'd1,
    RK_IO   = 2'd2
  } rkind_e;
endpackage

// File: rtl/mmap_region_dec.sv
module mmap_region_dec
  import mmap_pkg::*;
(
  input  logic [15:0]     addr_i,
  input  logic            ram_en_i,
  input  logic            clk_swap_i,
  output logic [NREG-1:0] hit_o,
  output logic [15:0]     eff_addr_o
);
  logic echo;

  // echo window folds onto work RAM
  assign echo       = (addr_i >= 16'hE000) && (addr_i < 16'hFE00);
  assign eff_addr_o = echo ? (addr_i & 16'hDFFF) : addr_i;

  always_comb begin
    hit_o = '0;
    if (!eff_addr_o[15]) begin
      if (eff_addr_o[14]) hit_o[RG_ROMX] = 1'b1;
      else                hit_o[RG_ROM0] = 1'b1;
    end else begin
      case (eff_addr_o[15:13])
        3'b100: hit_o[RG_VRAM] = 1'b1;
        3'b101: begin
          if (ram_en_i) begin
            if (clk_swap_i) hit_o[RG_CLK]  = 1'b1;
            else            hit_o[RG_XRAM] = 1'b1;
          end
        end
        3'b110: hit_o[RG_WRAM] = 1'b1;
        default: begin
          if (eff_addr_o[15:8] == 8'hFE) begin
            if (eff_addr_o[7:0] < 8'hA0) hit_o[RG_OAM] = 1'b1;
          end else if (!eff_addr_o[7]) begin
            hit_o[RG_IO] = 1'b1;
          end else if (eff_addr_o[6:0] != 7'h7F) begin
            hit_o[RG_HRAM] = 1'b1;
          end else begin
            hit_o[RG_IE] = 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mmap_bank_sel.sv
module mmap_bank_sel
  import mmap_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int WSEL_W     = 3,
  parameter int BANK_W     = 9,
  parameter int OFF_W      = 14
) (
  input  logic [NREG-1:0]       hit_i,
  input  logic [15:0]           eff_addr_i,
  input  logic [ROM_BANK_W-1:0] rom_bank_i,
  input  logic [RAM_BANK_W-1:0] ram_bank_i,
  input  logic [2:0]            clk_reg_i,
  input  logic                  vram_bank_i,
  input  logic [WSEL_W-1:0]     wram_sel_i,
  output logic [BANK_W-1:0]     bank_o,
  output logic [OFF_W-1:0]      offset_o
);
  logic [WSEL_W-1:0] wram_hi_bank;

  // bank 0 is not reachable through the upper work-RAM window
  assign wram_hi_bank = (wram_sel_i == '0) ? WSEL_W'(1) : wram_sel_i;

  always_comb begin
    bank_o   = '0;
    offset_o = '0;
    if (hit_i[RG_ROM0]) begin
      offset_o = OFF_W'(eff_addr_i[13:0]);
    end
    if (hit_i[RG_ROMX]) begin
      bank_o   = BANK_W'(rom_bank_i);
      offset_o = OFF_W'(eff_addr_i[13:0]);
    end
    if (hit_i[RG_VRAM]) begin
      bank_o   = BANK_W'(vram_bank_i);
      offset_o = OFF_W'(eff_addr_i[12:0]);
    end
    if (hit_i[RG_XRAM]) begin
      bank_o   = BANK_W'(ram_bank_i);
      offset_o = OFF_W'(eff_addr_i[12:0]);
    end
    if (hit_i[RG_CLK]) begin
      offset_o = OFF_W'(clk_reg_i);
    end
    if (hit_i[RG_WRAM]) begin
      bank_o   = eff_addr_i[12] ? BANK_W'(wram_hi_bank) : '0;
      offset_o = OFF_W'(eff_addr_i[11:0]);
    end
    if (hit_i[RG_OAM] || hit_i[RG_IO]) begin
      offset_o = OFF_W'(eff_addr_i[7:0]);
    end
    if (hit_i[RG_HRAM]) begin
      offset_o = OFF_W'(eff_addr_i[6:0]);
    end
  end
endmodule

// File: rtl/mmap_rdata_ret.sv
module mmap_rdata_ret
  import mmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_fire_i,
  input  rkind_e            kind_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] io_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] FILL = '1;

  rkind_e kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        kind_q <= RK_FILL;
    else if (rd_fire_i) kind_q <= kind_i;
  end

  always_comb begin
    case (kind_q)
      RK_MEM:  rdata_o = mem_rdata_i;
      RK_IO:   rdata_o = io_rdata_i;
      default: rdata_o = FILL;
    endcase
  end

  // R12
  fill_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire_i && kind_i == RK_FILL) |=> (rdata_o == FILL));

  // R12
  io_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire_i && kind_i == RK_IO) |=> (rdata_o == io_rdata_i));
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
  import mmap_pkg::*;
#(
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter int WSEL_W     = 3,
  parameter int DATA_W     = 8,
  parameter int OFF_W      = 14
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [15:0]            addr_i,
  input  logic [ROM_BANK_W-1:0]  rom_bank_i,
  input  logic [RAM_BANK_W-1:0]  ram_bank_i,
  input  logic                   ram_en_i,
  input  logic [3:0]             clk_sel_i,
  input  logic [7:0]             vram_bank_i,
  input  logic [7:0]             wram_bank_i,
  input  logic [DATA_W-1:0]      mem_rdata_i,
  input  logic [DATA_W-1:0]      io_rdata_i,
  output logic [NREG-1:0]        region_o,
  output logic [ROM_BANK_W-1:0]  bank_o,
  output logic [OFF_W-1:0]       offset_o,
  output logic                   mem_we_o,
  output logic                   ctrl_we_o,
  output logic                   io_re_o,
  output logic                   io_we_o,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam int BANK_W = ROM_BANK_W;

  logic [15:0] eff_addr;
  logic        rom_hit, io_hit, any_hit, mem_hit;
  logic        wr, rd;
  rkind_e      kind_d;

  mmap_region_dec i_dec (
    .addr_i     (addr_i),
    .ram_en_i   (ram_en_i),
    .clk_swap_i (clk_sel_i[3]),
    .hit_o      (region_o),
    .eff_addr_o (eff_addr)
  );

  mmap_bank_sel #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W),
    .WSEL_W     (WSEL_W),
    .BANK_W     (BANK_W),
    .OFF_W      (OFF_W)
  ) i_bank (
    .hit_i       (region_o),
    .eff_addr_i  (eff_addr),
    .rom_bank_i  (rom_bank_i),
    .ram_bank_i  (ram_bank_i),
    .clk_reg_i   (clk_sel_i[2:0]),
    .vram_bank_i (vram_bank_i[0]),
    .wram_sel_i  (wram_bank_i[WSEL_W-1:0]),
    .bank_o      (bank_o),
    .offset_o    (offset_o)
  );

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign rom_hit = region_o[RG_ROM0] | region_o[RG_ROMX];
  assign io_hit  = region_o[RG_IO];
  assign any_hit = |region_o;
  assign mem_hit = any_hit & ~rom_hit & ~io_hit;

  assign ctrl_we_o = wr & rom_hit;
  assign mem_we_o  = wr & mem_hit;
  assign io_we_o   = wr & io_hit;
  assign io_re_o   = rd & io_hit;

  assign kind_d = io_hit ? RK_IO : (any_hit ? RK_MEM : RK_FILL);

  mmap_rdata_ret #(.DATA_W(DATA_W)) i_ret (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_fire_i   (rd),
    .kind_i      (kind_d),
    .mem_rdata_i (mem_rdata_i),
    .io_rdata_i  (io_rdata_i),
    .rdata_o     (rdata_o)
  );

  // R11
  region_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(region_o));

  // R2
  ctrl_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |-> (!mem_we_o && !io_we_o && !addr_i[15]));

  // R4
  xram_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:13] == 3'b101 && !ram_en_i) |-> (region_o == '0 && !mem_we_o));

  // R6
  wram_hi_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o[RG_WRAM] && addr_i[12]) |-> (bank_o != '0));

  // R10
  ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 16'hFFFF) |-> region_o[RG_IE]);

  // R9
  io_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_re_o || io_we_o) |-> (addr_i[15:7] == 9'h1FE));
endmodule

// File: tb/test_mem_region_decoder.sv
`timescale 1ns/1ps
module test_mem_region_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [8:0]  rom_bank = 9'd1;
  logic [3:0]  ram_bank = '0;
  logic        ram_en = 1'b0;
  logic [3:0]  clk_sel = '0;
  logic [7:0]  vbank = '0, wbank = '0;
  logic [7:0]  mem_rd = 8'h11, io_rd = 8'h22;
  logic [9:0]  region;
  logic [8:0]  bank;
  logic [13:0] offset;
  logic        mem_we, ctrl_we, io_re, io_we;
  logic [7:0]  rdata;

  int checks = 0, bad = 0;
  int exp_kind = 0;  // 0 fill, 1 mem, 2 io
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  mem_region_decoder i_mem_region_decoder (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .rom_bank_i(rom_bank), .ram_bank_i(ram_bank), .ram_en_i(ram_en),
    .clk_sel_i(clk_sel), .vram_bank_i(vbank), .wram_bank_i(wbank),
    .mem_rdata_i(mem_rd), .io_rdata_i(io_rd), .region_o(region),
    .bank_o(bank), .offset_o(offset), .mem_we_o(mem_we), .ctrl_we_o(ctrl_we),
    .io_re_o(io_re), .io_we_o(io_we), .rdata_o(rdata)
  );

  // reference: region index (-1 none), bank, offset, requirement tag
  function automatic void model(input int a_in, output int rg, output int bk,
                                output int off, output string tag);
    int a = a_in;
    tag = "";
    if (a >= 'hE000 && a < 'hFE00) begin a = a & 'hDFFF; tag = "R7/"; end
    bk = 0; off = 0; rg = -1;
    if (a < 'h4000)      begin rg = 0; off = a & 'h3FFF; tag = {tag, "R1"}; end
    else if (a < 'h8000) begin rg = 1; bk = rom_bank; off = a & 'h3FFF; tag = {tag, "R1"}; end
    else if (a < 'hA000) begin rg = 2; bk = vbank & 1; off = a & 'h1FFF; tag = {tag, "R3"}; end
    else if (a < 'hC000) begin
      if (!ram_en) tag = {tag, "R4"};
      else if (clk_sel[3]) begin rg = 4; off = clk_sel & 7; tag = {tag, "R5"}; end
      else begin rg = 3; bk = ram_bank; off = a & 'h1FFF; tag = {tag, "R5"}; end
    end
    else if (a < 'hD000) begin rg = 5; off = a & 'hFFF; tag = {tag, "R6"}; end
    else if (a < 'hE000) begin
      rg = 5; bk = wbank & 7; if (bk == 0) bk = 1; off = a & 'hFFF; tag = {tag, "R6"};
    end
    else if (a < 'hFEA0) begin rg = 6; off = a & 'hFF; tag = {tag, "R8"}; end
    else if (a < 'hFF00) tag = {tag, "R8"};
    else if (a < 'hFF80) begin rg = 7; off = a & 'hFF; tag = {tag, "R9"}; end
    else if (a < 'hFFFF) begin rg = 8; off = a & 'h7F; tag = {tag, "R10"}; end
    else begin rg = 9; tag = {tag, "R10"}; end
  endfunction

  function automatic int kind_of(input int rg);
    if (rg < 0) return 0;
    if (rg == 7) return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    int rg, bk, off; string tg;
    model(addr, rg, bk, off, tg);
    if (rst_n && req && !we) exp_kind <= kind_of(rg);
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s addr=%04h act=%0h exp=%0h", tag, what, addr, act, exp);
    end
  endtask

  task automatic compare();
    int rg, bk, off, er; string tg;
    logic [9:0] exp_region;
    bit wr, rd, isrom, isio;
    model(addr, rg, bk, off, tg);
    exp_region = (rg < 0) ? 10'd0 : (10'd1 << rg);
    wr = req && we; rd = req && !we;
    isrom = (rg == 0 || rg == 1); isio = (rg == 7);
    chk(region == exp_region, {tg, "/R11"}, "region", region, exp_region);
    chk(int'(bank) == bk, {tg, "/R11"}, "bank", bank, bk);
    chk(int'(offset) == off, {tg, "/R11"}, "offset", offset, off);
    chk(ctrl_we == (wr && isrom), {tg, "/R2"}, "ctrl_we", ctrl_we, wr && isrom);
    chk(mem_we == (wr && rg >= 0 && !isrom && !isio), {tg, "/R13"}, "mem_we",
        mem_we, wr && rg >= 0 && !isrom && !isio);
    chk(io_we == (wr && isio), {tg, "/R9"}, "io_we", io_we, wr && isio);
    chk(io_re == (rd && isio), {tg, "/R9"}, "io_re", io_re, rd && isio);
    er = (exp_kind == 0) ? 'hFF : (exp_kind == 2) ? int'(io_rd) : int'(mem_rd);
    chk(int'(rdata) == er, "R12", "rdata", rdata, er);
  endtask

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  // compare at falling edge, then drive the next access
  task automatic step(input bit r, input bit w, input int a);
    @(negedge clk);
    compare();
    req = r; we = w; addr = 16'(a);
    mem_rd = 8'(rnd()); io_rd = 8'(rnd());
  endtask

  int edges[25] = '{'h0000, 'h3FFF, 'h4000, 'h7FFF, 'h8000, 'h9FFF, 'hA000,
                    'hBFFF, 'hC000, 'hCFFF, 'hD000, 'hDFFF, 'hE000, 'hEFFF,
                    'hF000, 'hFDFF, 'hFE00, 'hFE9F, 'hFEA0, 'hFEFF, 'hFF00,
                    'hFF7F, 'hFF80, 'hFFFE, 'hFFFF};

  initial begin
    repeat (3) @(negedge clk);
    // reset state: no read yet, fill returned (R12)
    compare();
    rst_n = 1'b1;
    for (int cfg = 0; cfg < 8; cfg++) begin
      ram_en   = cfg[0];
      clk_sel  = cfg[1] ? 4'hD : 4'h2;
      wbank    = cfg[2] ? 8'hF8 : 8'h05;   // 0 promotes to 1 (R6)
      vbank    = cfg[2] ? 8'h01 : 8'hFE;
      rom_bank = cfg[2] ? 9'h1A5 : 9'h003;
      ram_bank = cfg[1] ? 4'hB : 4'h2;
      for (int i = 0; i < 25; i++) begin
        step(1'b1, 1'b0, edges[i]);
        step(1'b1, 1'b1, edges[i]);
        step(1'b0, 1'b0, edges[i]);
      end
    end
    for (int n = 0; n < 4000; n++) begin
      int unsigned v = rnd();
      rom_bank = 9'(v); ram_bank = 4'(v >> 9); ram_en = v[13];
      clk_sel = 4'(v >> 14); vbank = 8'(v >> 18); wbank = 8'(v >> 24);
      v = rnd();
      step(v[16], v[17], int'(v[15:0]));
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(8ns * 100000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule